// File: doc/BRIEF.md
# System Register Access Permission and Trap Decoder

This block sits beside one system register of a virtual interrupt interface. It inspects every system register access the core presents, together with the privilege level the access comes from and a handful of control bits. It then gives one verdict. The access may be carried out on the register directly, or sent to a fixed slot in memory. It may be trapped to privilege level 2 or 3 with an exception class code, or it may be reported as undefined. An access whose encoding belongs to some other register is answered with a "not mine" verdict, and nothing else happens for it.

The control inputs are:

- a flag saying the hypervisor level is enabled;
- a primary nested-virtualisation bit, which makes level 1 accesses trap;
- a secondary nested-virtualisation bit, which together with the primary bit turns trapping into memory redirection;
- a system-interface enable bit for level 2;
- a system-interface enable bit for level 3.

A request is accepted in any cycle in which `req_valid` is high. Its verdict is registered and presented for exactly one cycle, one cycle later, so a new request may be issued every cycle. Register storage and the memory backing belong to neighbouring blocks.

Top module: `sysreg_access_gate`

## Requirements
- R1: The register is selected only when op0=2'b11, op1=3'b100, CRn=4'b1100, CRm=4'b1011 and op2=3'b111. If any field differs, the verdict is `rsp_not_mine` alone, whatever the privilege level and control inputs are.
- R2: A matching access from privilege level 0 (`req_level`=0) is undefined (`rsp_undef`).
- R3: A matching access from level 1 is redirected to memory (`rsp_redirect`, with `rsp_mem_offset`=12'h4C8) when the hypervisor is enabled and both nested bits are 1.
- R4: A matching level 1 access traps (`rsp_trap`) when the hypervisor is enabled, the primary nested bit is 1 and the secondary bit is 0. The trap goes to level 2 (`rsp_trap_level`=2) with class code 6'h18.
- R5: Any other matching level 1 access is undefined. This covers the hypervisor being disabled, and the primary nested bit being 0 whatever the secondary bit is.
- R6: A matching level 2 access is performed (`rsp_access`) when the level 2 enable bit is 1. When that bit is 0, it traps to level 2 with class 6'h18.
- R7: A matching level 3 access is performed when the level 3 enable bit is 1. When that bit is 0, it traps to level 3 (`rsp_trap_level`=3) with class 6'h18.
- R8: Reads and writes get identical verdicts. `rsp_write` repeats the request's write flag while `rsp_valid` is high.
- R9: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and in that cycle exactly one outcome flag is high. When `rsp_valid` is low, all outcome flags, `rsp_write`, `rsp_mem_offset`, `rsp_trap_level` and `rsp_trap_class` are 0. The offset is non-zero only with a redirect, and the level and class are non-zero only with a trap.
- R10: While `rst_n` is low and after its release, `rsp_valid` and every outcome flag read 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_level | input | 2 | Privilege level of the access, 0 to 3 |
| hyp_en | input | 1 | Hypervisor level enabled for lower levels |
| nest_trap | input | 1 | Primary nested-virtualisation bit |
| nest_redirect | input | 1 | Secondary nested-virtualisation bit |
| l2_sysif_en | input | 1 | System-interface enable for level 2 |
| l3_sysif_en | input | 1 | System-interface enable for level 3 |
| rsp_valid | output | 1 | Verdict present this cycle |
| rsp_write | output | 1 | Write flag of the judged request |
| rsp_access | output | 1 | Perform the register access |
| rsp_redirect | output | 1 | Redirect the access to memory |
| rsp_mem_offset | output | 12 | Memory slot offset for a redirect |
| rsp_trap | output | 1 | Take a trap |
| rsp_trap_level | output | 2 | Target level of the trap |
| rsp_trap_class | output | 6 | Exception class code of the trap |
| rsp_undef | output | 1 | Access is undefined |
| rsp_not_mine | output | 1 | Encoding belongs to another register |

## Verification
Two functions can act on the same request: encoding-miss detection and the privilege rules. A near-miss encoding is one that differs from the selected encoding in a single field. The bench issues near-miss encodings from every privilege level, with control settings that on their own would undefine, trap or redirect the access. Each such request must end as `rsp_not_mine` alone. Requests are also issued back to back, so that one verdict is checked in the same cycle the next request is accepted. Each verdict is judged against a model in the bench that restates the rules in its own order.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [2:0] {
    OC_NONE     = 3'd0,
    OC_ACCESS   = 3'd1,
    OC_REDIRECT = 3'd2,
    OC_TRAP     = 3'd3,
    OC_UNDEF    = 3'd4,
    OC_FOREIGN  = 3'd5
  } outcome_e;

  localparam int unsigned NUM_FLAGS = 5;

  typedef struct packed {
    outcome_e   kind;
    logic [1:0] trap_level;
  } verdict_t;

  // Priority-ordered privilege rules. An encoding miss wins over every level rule.
  function automatic verdict_t judge(
    input logic       hit,
    input logic [1:0] level,
    input logic       hyp_en,
    input logic       nest_trap,
    input logic       nest_redirect,
    input logic       l2_en,
    input logic       l3_en
  );
    verdict_t v;
    v.kind       = OC_UNDEF;
    v.trap_level = 2'd0;
    if (!hit) begin
      v.kind = OC_FOREIGN;
    end else begin
      unique case (level)
        2'd0: v.kind = OC_UNDEF;
        2'd1: begin
          if (hyp_en && nest_trap && nest_redirect) begin
            v.kind = OC_REDIRECT;
          end else if (hyp_en && nest_trap) begin
            v.kind       = OC_TRAP;
            v.trap_level = 2'd2;
          end else begin
            v.kind = OC_UNDEF;
          end
        end
        2'd2: begin
          if (l2_en) begin
            v.kind = OC_ACCESS;
          end else begin
            v.kind       = OC_TRAP;
            v.trap_level = 2'd2;
          end
        end
        default: begin
          if (l3_en) begin
            v.kind = OC_ACCESS;
          end else begin
            v.kind       = OC_TRAP;
            v.trap_level = 2'd3;
          end
        end
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/sag_enc_match.sv
module sag_enc_match #(
  parameter int unsigned OP0_W = 2,
  parameter int unsigned OP1_W = 3,
  parameter int unsigned CRN_W = 4,
  parameter int unsigned CRM_W = 4,
  parameter int unsigned OP2_W = 3,
  parameter logic [OP0_W-1:0] SEL_OP0 = 2'b11,
  parameter logic [OP1_W-1:0] SEL_OP1 = 3'b100,
  parameter logic [CRN_W-1:0] SEL_CRN = 4'b1100,
  parameter logic [CRM_W-1:0] SEL_CRM = 4'b1011,
  parameter logic [OP2_W-1:0] SEL_OP2 = 3'b111
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);
  localparam int unsigned ENC_W = OP0_W + OP1_W + CRN_W + CRM_W + OP2_W;
  localparam logic [ENC_W-1:0] SEL_ENC = {SEL_OP0, SEL_OP1, SEL_CRN, SEL_CRM, SEL_OP2};

  logic [ENC_W-1:0] enc;
  logic [ENC_W-1:0] diff;

  assign enc  = {op0, op1, crn, crm, op2};
  assign diff = enc ^ SEL_ENC;
  assign hit  = (diff == '0);
endmodule

// File: rtl/sag_rules.sv
module sag_rules
  import sag_pkg::*;
(
  input  logic       hit,
  input  logic [1:0] level,
  input  logic       hyp_en,
  input  logic       nest_trap,
  input  logic       nest_redirect,
  input  logic       l2_en,
  input  logic       l3_en,
  output verdict_t   verdict,
  output logic       lvl1_nested,
  output logic       lvl_high_blocked
);
  assign verdict = judge(hit, level, hyp_en, nest_trap, nest_redirect, l2_en, l3_en);

  // Named events for the checks next to this logic.
  assign lvl1_nested      = hit && (level == 2'd1) && hyp_en && nest_trap;
  assign lvl_high_blocked = hit && (((level == 2'd2) && !l2_en) || ((level == 2'd3) && !l3_en));
endmodule

// File: rtl/sag_out_reg.sv
module sag_out_reg
  import sag_pkg::*;
#(
  parameter int unsigned OFFS_W  = 12,
  parameter int unsigned CLASS_W = 6,
  parameter logic [OFFS_W-1:0]  MEM_OFFSET = 12'h4C8,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_write,
  input  verdict_t            in_verdict,
  output logic                out_valid,
  output logic                out_write,
  output logic [NUM_FLAGS-1:0] out_flags,
  output logic [OFFS_W-1:0]   out_offset,
  output logic [1:0]          out_trap_level,
  output logic [CLASS_W-1:0]  out_trap_class
);
  logic       v_q;
  logic       w_q;
  outcome_e   k_q;
  logic [1:0] tl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      w_q  <= 1'b0;
      k_q  <= OC_NONE;
      tl_q <= 2'd0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        w_q  <= in_write;
        k_q  <= in_verdict.kind;
        tl_q <= in_verdict.trap_level;
      end
    end
  end

  // Flag i stands for outcome code i+1: access, redirect, trap, undef, foreign.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign out_flags[i] = v_q && (logic'(k_q == outcome_e'(3'(i + 1))));
  end

  assign out_valid      = v_q;
  assign out_write      = v_q && w_q;
  assign out_offset     = out_flags[1] ? MEM_OFFSET : '0;
  assign out_trap_level = out_flags[2] ? tl_q : 2'd0;
  assign out_trap_class = out_flags[2] ? TRAP_CLASS : '0;

  // R9: one verdict per valid cycle, silence otherwise.
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_flags) == 1));
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_flags == '0 && out_offset == '0 && out_trap_class == '0));
  // R10: output valid follows the accepted request register.
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
endmodule

// File: rtl/sysreg_access_gate.sv
module sysreg_access_gate
  import sag_pkg::*;
#(
  parameter int unsigned OFFS_W  = 12,
  parameter int unsigned CLASS_W = 6,
  parameter logic [OFFS_W-1:0]  MEM_OFFSET = 12'h4C8,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op0,
  input  logic [2:0]         req_op1,
  input  logic [3:0]         req_crn,
  input  logic [3:0]         req_crm,
  input  logic [2:0]         req_op2,
  input  logic               req_write,
  input  logic [1:0]         req_level,
  input  logic               hyp_en,
  input  logic               nest_trap,
  input  logic               nest_redirect,
  input  logic               l2_sysif_en,
  input  logic               l3_sysif_en,
  output logic               rsp_valid,
  output logic               rsp_write,
  output logic               rsp_access,
  output logic               rsp_redirect,
  output logic [OFFS_W-1:0]  rsp_mem_offset,
  output logic               rsp_trap,
  output logic [1:0]         rsp_trap_level,
  output logic [CLASS_W-1:0] rsp_trap_class,
  output logic               rsp_undef,
  output logic               rsp_not_mine
);
  logic                 enc_hit;
  verdict_t             verdict;
  logic                 lvl1_nested;
  logic                 lvl_high_blocked;
  logic [NUM_FLAGS-1:0] flags;

  sag_enc_match u_match (
    .op0 (req_op0),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (enc_hit)
  );

  sag_rules u_rules (
    .hit              (enc_hit),
    .level            (req_level),
    .hyp_en           (hyp_en),
    .nest_trap        (nest_trap),
    .nest_redirect    (nest_redirect),
    .l2_en            (l2_sysif_en),
    .l3_en            (l3_sysif_en),
    .verdict          (verdict),
    .lvl1_nested      (lvl1_nested),
    .lvl_high_blocked (lvl_high_blocked)
  );

  sag_out_reg #(
    .OFFS_W     (OFFS_W),
    .CLASS_W    (CLASS_W),
    .MEM_OFFSET (MEM_OFFSET),
    .TRAP_CLASS (TRAP_CLASS)
  ) u_out (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (req_valid),
    .in_write       (req_write),
    .in_verdict     (verdict),
    .out_valid      (rsp_valid),
    .out_write      (rsp_write),
    .out_flags      (flags),
    .out_offset     (rsp_mem_offset),
    .out_trap_level (rsp_trap_level),
    .out_trap_class (rsp_trap_class)
  );

  assign rsp_access   = flags[0];
  assign rsp_redirect = flags[1];
  assign rsp_trap     = flags[2];
  assign rsp_undef    = flags[3];
  assign rsp_not_mine = flags[4];

  // R1: a miss yields only the foreign verdict.
  p_miss_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !enc_hit) |=> (rsp_not_mine && !rsp_undef && !rsp_trap));
  // R2: level 0 is always undefined.
  p_level0_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enc_hit && req_level == 2'd0) |=> rsp_undef);
  // R3: redirect carries the fixed slot.
  p_redirect_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_redirect |-> (rsp_mem_offset == MEM_OFFSET));
  // R4: nested level 1 access never reaches the register.
  p_nested_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lvl1_nested) |=> (rsp_redirect || (rsp_trap && rsp_trap_level == 2'd2)));
  // R6 / R7: a blocked upper level traps to its own level with the class code.
  p_blocked_traps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lvl_high_blocked) |=> (rsp_trap && rsp_trap_level == $past(req_level)
                                          && rsp_trap_class == TRAP_CLASS));
  // R8: write flag carried with the verdict.
  p_write_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_write == $past(req_write)));
  // R9: verdict appears one cycle after the request.
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/sysreg_access_gate_test.sv
module sysreg_access_gate_test;
  localparam int PERIOD = 10;
  localparam logic [1:0] K_OP0 = 2'b11;
  localparam logic [2:0] K_OP1 = 3'b100;
  localparam logic [3:0] K_CRN = 4'b1100;
  localparam logic [3:0] K_CRM = 4'b1011;
  localparam logic [2:0] K_OP2 = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op0 = '0;
  logic [2:0] req_op1 = '0;
  logic [3:0] req_crn = '0;
  logic [3:0] req_crm = '0;
  logic [2:0] req_op2 = '0;
  logic req_write = 1'b0;
  logic [1:0] req_level = '0;
  logic hyp_en = 1'b0, nest_trap = 1'b0, nest_redirect = 1'b0;
  logic l2_sysif_en = 1'b0, l3_sysif_en = 1'b0;
  logic rsp_valid, rsp_write, rsp_access, rsp_redirect, rsp_trap, rsp_undef, rsp_not_mine;
  logic [11:0] rsp_mem_offset;
  logic [1:0]  rsp_trap_level;
  logic [5:0]  rsp_trap_class;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sysreg_access_gate uut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Expected flags {not_mine, undef, trap, redirect, access} and trap level.
  function automatic logic [6:0] model(input logic match, input logic [1:0] lvl,
                                       input logic hy, input logic nt, input logic nr,
                                       input logic e2, input logic e3);
    if (!match) return {5'b10000, 2'd0};
    if (lvl == 2'd3) return e3 ? {5'b00001, 2'd0} : {5'b00100, 2'd3};
    if (lvl == 2'd2) return e2 ? {5'b00001, 2'd0} : {5'b00100, 2'd2};
    if (lvl == 2'd0) return {5'b01000, 2'd0};
    if (!hy || !nt) return {5'b01000, 2'd0};
    return nr ? {5'b00010, 2'd0} : {5'b00100, 2'd2};
  endfunction

  // Drive one request at the current falling edge; check its verdict at the next one.
  task automatic issue(input string tag, input logic [15:0] enc, input logic wr,
                       input logic [1:0] lvl, input logic hy, input logic nt, input logic nr,
                       input logic e2, input logic e3);
    logic [6:0] e;
    logic       match;
    {req_op0, req_op1, req_crn, req_crm, req_op2} = enc;
    req_write = wr; req_level = lvl; hyp_en = hy; nest_trap = nt; nest_redirect = nr;
    l2_sysif_en = e2; l3_sysif_en = e3; req_valid = 1'b1;
    match = (enc == {K_OP0, K_OP1, K_CRN, K_CRM, K_OP2});
    e = model(match, lvl, hy, nt, nr, e2, e3);
    @(negedge clk);
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " flags"}, 32'({rsp_not_mine, rsp_undef, rsp_trap, rsp_redirect, rsp_access}),
          32'(e[6:2]));
    check({tag, " trap level"}, 32'(rsp_trap_level), 32'(e[1:0]));
    check({tag, " class"}, 32'(rsp_trap_class), e[4] ? 32'h18 : 32'h0);
    check({tag, " offset"}, 32'(rsp_mem_offset), e[3] ? 32'h4C8 : 32'h0);
    check({tag, " write R8"}, 32'(rsp_write), 32'(wr));
  endtask

  task automatic go_idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    check({tag, " idle valid"}, 32'(rsp_valid), 32'd0);
    check({tag, " idle flags"}, 32'({rsp_not_mine, rsp_undef, rsp_trap, rsp_redirect, rsp_access,
          rsp_write}), 32'd0);
    check({tag, " idle fields"}, 32'({rsp_mem_offset, rsp_trap_level, rsp_trap_class}), 32'd0);
  endtask

  localparam logic [15:0] SEL = {K_OP0, K_OP1, K_CRN, K_CRM, K_OP2};

  task automatic t_reset();
    @(negedge clk);
    check("R10 in reset", 32'({rsp_valid, rsp_access, rsp_undef, rsp_not_mine}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 32'({rsp_valid, rsp_trap, rsp_redirect}), 32'd0);
  endtask

  task automatic t_near_miss();
    // R1: flip one bit in each field, from each level, with trap-prone controls.
    for (int b = 0; b < 16; b++) begin
      issue("R1 near miss", SEL ^ (16'd1 << b), 1'(b % 2), 2'(b % 4), 1'b1, 1'b1,
            1'(b % 3 == 0), 1'b0, 1'b0);
    end
    go_idle("R1");
  endtask

  task automatic t_level0();
    for (int c = 0; c < 32; c++) begin
      issue("R2 level0", SEL, 1'(c % 2), 2'd0, c[0], c[1], c[2], c[3], c[4]);
    end
    go_idle("R2");
  endtask

  task automatic t_level1();
    issue("R3 redirect", SEL, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    issue("R3 redirect write", SEL, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    issue("R4 trap", SEL, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    issue("R5 secondary alone", SEL, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    issue("R5 hyp off", SEL, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int c = 0; c < 32; c++) begin
      issue("R5 level1 sweep", SEL, 1'(c / 16), 2'd1, c[0], c[1], c[2], c[3], c[4]);
    end
    go_idle("R3");
  endtask

  task automatic t_upper();
    issue("R6 access", SEL, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    issue("R6 trap", SEL, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    issue("R7 access", SEL, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    issue("R7 trap", SEL, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    go_idle("R7");
  endtask

  task automatic t_read_write();
    // R8: every level and control setting, as a read and as a write.
    for (int c = 0; c < 128; c++) begin
      issue("R8 sweep", SEL, c[0], c[2:1], c[3], c[4], c[5], c[6], ~c[6]);
    end
    go_idle("R8");
  endtask

  task automatic t_gap();
    // R9: isolated requests separated by idle cycles.
    issue("R9 single", SEL, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    go_idle("R9 a");
    go_idle("R9 b");
    issue("R9 single miss", 16'h0000, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    go_idle("R9 c");
  endtask

  initial begin
    t_reset();
    t_near_miss();
    t_level0();
    t_level1();
    t_upper();
    t_read_write();
    t_gap();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule